// File: doc/BRIEF.md
# SDRAM Command Timing Guard

The guard sits between a memory controller's command scheduler and the command bus of a DDR SDRAM. Each clock the scheduler offers one command (activate with a bank, read, write, precharge, auto-refresh, self-refresh entry, self-refresh exit or no-operation). The guard raises `cmd_ready` only when every minimum spacing that applies to that command has run out, so that a command crossing the boundary is always legal for the device. Minimum spacings are parameters. Those given in picoseconds are turned into clock cycles by dividing by the clock period and rounding up to the next whole cycle.

The offered command is a valid/ready stream. A command is issued in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is a combinational function of the offered type and bank and of the guard's timer state, and it does not depend on `cmd_valid`. A refused command has no effect. The scheduler keeps it (type and bank unchanged) on the inputs with `cmd_valid` high until it is accepted. All timers reload on the clock edge that ends the issuing cycle.

The guard also tracks auto-refreshes that are owed. An external interval generator pulses `refresh_due` each time a refresh falls due, and each issued auto-refresh pays one back. At most `MAX_POSTED` refreshes may be owed, and a due pulse arriving at that limit is flagged.

Top module: `cmd_timing_guard`

## Requirements
- R1: After an auto-refresh is issued in cycle t, neither an activate nor another auto-refresh (nor self-refresh entry) is ready before cycle t+ceil(T_RFC_PS/CLK_PS). With the defaults this is 19 cycles.
- R2: After a precharge to bank b in cycle t, an activate to bank b is not ready before cycle t+ceil(T_RP_PS/CLK_PS), which is 5 by default. Other banks are not delayed by it.
- R3: After an activate to bank a in cycle t, an activate to a bank other than a is not ready before cycle t+ceil(T_RRD_PS/CLK_PS), which is 4 by default. An activate to bank a itself is not held back by this spacing.
- R4: After a write to bank b in cycle t, a precharge to bank b is not ready before cycle t+WR_DATA_CK+ceil(T_WR_PS/CLK_PS), which is 3+4=7 by default. The last write data beat ends WR_DATA_CK cycles after the command.
- R5: After a write to any bank in cycle t, a read is not ready before cycle t+WR_DATA_CK+T_WTR_CK, which is 4 by default.
- R6: After self-refresh exit in cycle t, every command other than read and no-operation waits until cycle t+ceil(T_XSNR_PS/CLK_PS), which is 19 by default. A read waits until cycle t+T_XSRD_CK, which is 200 by default.
- R7: Between a self-refresh entry and the next exit, only self-refresh exit (code 7) and no-operation (code 0) are ready. Outside self-refresh, self-refresh exit is never ready.
- R8: A no-operation (code 0) is always ready. A command that is refused changes no timer. Command codes are: 0 no-operation, 1 activate, 2 read, 3 write, 4 precharge, 5 auto-refresh, 6 self-refresh entry, 7 self-refresh exit.
- R9: `posted_cnt` rises by one after a cycle with `refresh_due` high and no issued auto-refresh, and falls by one after an issued auto-refresh with `refresh_due` low. It stops at `MAX_POSTED` (8) at the top and at 0 at the bottom. It is unchanged when both happen in the same cycle.
- R10: `posted_ovf` is high in exactly those cycles where `refresh_due` is high, no auto-refresh is issued and `posted_cnt` already equals `MAX_POSTED`.
- R11: After reset, `posted_cnt` is 0, `posted_ovf` is 0, the device is taken to be out of self-refresh, and every command except self-refresh exit is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Offered command is valid |
| cmd_type | input | 3 | Command code (see R8) |
| cmd_bank | input | BANK_W (2) | Target bank for activate, precharge, read and write |
| cmd_ready | output | 1 | Offered command meets all spacings |
| refresh_due | input | 1 | One-cycle pulse: one more auto-refresh is owed |
| posted_cnt | output | CNT_W (4) | Number of auto-refreshes currently owed |
| posted_ovf | output | 1 | Due pulse arrived with the owed count at its limit |

## Verification
`cmd_ready` and `posted_ovf` are due in the same cycle as the inputs that cause them. A spacing of d cycles counted from an issue in cycle t first lets the dependent command through in cycle t+d, and `posted_cnt` moves one edge after the cycle that changes it. The bench drives each cycle's inputs just after the rising edge. It compares the outputs on the falling edge against a model of last-issue cycle numbers, and only then advances that model at the next rising edge. Every cycle of a directed pair sweep, a self-refresh sequence, a refresh-debt sequence and a randomized held-command stream is compared in this way.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_SRE = 3'd6,
    CMD_SRX = 3'd7
  } cmd_e;

  // picoseconds to whole clock cycles, rounded up
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  // bits needed to hold values 0..v
  function automatic int unsigned width_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         idle
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/bank_timers.sv
module bank_timers #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned RP_LOAD   = 4,
  parameter int unsigned WR_LOAD   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pre_fire,
  input  logic                 wr_fire,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] rp_idle,
  output logic [NUM_BANKS-1:0] wr_idle
);
  import sdram_guard_pkg::*;

  localparam int unsigned RP_W = width_for(RP_LOAD);
  localparam int unsigned WR_W = width_for(WR_LOAD);
  localparam logic [RP_W-1:0] RP_VAL = RP_W'(RP_LOAD);
  localparam logic [WR_W-1:0] WR_VAL = WR_W'(WR_LOAD);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(b));

    gap_timer #(.W(RP_W)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(pre_fire && hit),
      .load_val(RP_VAL), .idle(rp_idle[b])
    );

    gap_timer #(.W(WR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .load(wr_fire && hit),
      .load_val(WR_VAL), .idle(wr_idle[b])
    );
  end
endmodule

// File: rtl/refresh_tracker.sv
module refresh_tracker #(
  parameter int unsigned MAX_POSTED = 8,
  parameter int unsigned CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             due,
  input  logic             ref_fire,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_POSTED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (due && !ref_fire) begin
      if (cnt != CAP) cnt <= cnt + 1'b1;
    end else if (ref_fire && !due) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign ovf = due && !ref_fire && (cnt == CAP);
endmodule

// File: rtl/cmd_timing_guard.sv
module cmd_timing_guard
  import sdram_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned CLK_PS     = 4000,
  parameter int unsigned T_RFC_PS   = 75000,
  parameter int unsigned T_RP_PS    = 20000,
  parameter int unsigned T_RRD_PS   = 15000,
  parameter int unsigned T_WR_PS    = 15000,
  parameter int unsigned T_XSNR_PS  = 75000,
  parameter int unsigned T_WTR_CK   = 1,
  parameter int unsigned T_XSRD_CK  = 200,
  parameter int unsigned WR_DATA_CK = 3,
  parameter int unsigned MAX_POSTED = 8,
  parameter int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int unsigned CNT_W      = $clog2(MAX_POSTED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_type,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_ready,
  input  logic              refresh_due,
  output logic [CNT_W-1:0]  posted_cnt,
  output logic              posted_ovf
);
  // spacings in cycles; timers load (spacing - 1) on the issuing edge
  localparam int unsigned RFC_CYC  = ps_to_cyc(T_RFC_PS, CLK_PS);
  localparam int unsigned RP_CYC   = ps_to_cyc(T_RP_PS, CLK_PS);
  localparam int unsigned RRD_CYC  = ps_to_cyc(T_RRD_PS, CLK_PS);
  localparam int unsigned WR_CYC   = ps_to_cyc(T_WR_PS, CLK_PS);
  localparam int unsigned XSNR_CYC = ps_to_cyc(T_XSNR_PS, CLK_PS);

  localparam int unsigned RFC_LD  = RFC_CYC - 1;
  localparam int unsigned RRD_LD  = RRD_CYC - 1;
  localparam int unsigned WTR_LD  = WR_DATA_CK + T_WTR_CK - 1;
  localparam int unsigned XSNR_LD = XSNR_CYC - 1;
  localparam int unsigned XSRD_LD = T_XSRD_CK - 1;

  localparam int unsigned RFC_W  = width_for(RFC_LD);
  localparam int unsigned RRD_W  = width_for(RRD_LD);
  localparam int unsigned WTR_W  = width_for(WTR_LD);
  localparam int unsigned XSNR_W = width_for(XSNR_LD);
  localparam int unsigned XSRD_W = width_for(XSRD_LD);

  cmd_e ct;
  assign ct = cmd_e'(cmd_type);

  logic fire;
  assign fire = cmd_valid && cmd_ready;

  logic [NUM_BANKS-1:0] rp_idle, wr_idle;
  logic rfc_idle, rrd_idle, wtr_idle, xsnr_idle, xsrd_idle;
  logic in_sr_q;
  logic [BANK_W-1:0] last_act_q;

  bank_timers #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
    .RP_LOAD(RP_CYC - 1), .WR_LOAD(WR_DATA_CK + WR_CYC - 1)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .pre_fire(fire && ct == CMD_PRE),
    .wr_fire(fire && ct == CMD_WR),
    .bank(cmd_bank),
    .rp_idle(rp_idle), .wr_idle(wr_idle)
  );

  gap_timer #(.W(RFC_W)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load(fire && ct == CMD_REF),
    .load_val(RFC_W'(RFC_LD)), .idle(rfc_idle)
  );

  gap_timer #(.W(RRD_W)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(fire && ct == CMD_ACT),
    .load_val(RRD_W'(RRD_LD)), .idle(rrd_idle)
  );

  gap_timer #(.W(WTR_W)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(fire && ct == CMD_WR),
    .load_val(WTR_W'(WTR_LD)), .idle(wtr_idle)
  );

  gap_timer #(.W(XSNR_W)) u_xsnr (
    .clk(clk), .rst_n(rst_n), .load(fire && ct == CMD_SRX),
    .load_val(XSNR_W'(XSNR_LD)), .idle(xsnr_idle)
  );

  gap_timer #(.W(XSRD_W)) u_xsrd (
    .clk(clk), .rst_n(rst_n), .load(fire && ct == CMD_SRX),
    .load_val(XSRD_W'(XSRD_LD)), .idle(xsrd_idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sr_q    <= 1'b0;
      last_act_q <= '0;
    end else if (fire) begin
      if (ct == CMD_SRE) in_sr_q <= 1'b1;
      if (ct == CMD_SRX) in_sr_q <= 1'b0;
      if (ct == CMD_ACT) last_act_q <= cmd_bank;
    end
  end

  always_comb begin
    cmd_ready = 1'b0;
    if (in_sr_q) begin
      cmd_ready = (ct == CMD_SRX) || (ct == CMD_NOP);
    end else begin
      unique case (ct)
        CMD_NOP: cmd_ready = 1'b1;
        CMD_ACT: cmd_ready = xsnr_idle && rfc_idle && rp_idle[cmd_bank] &&
                             (rrd_idle || cmd_bank == last_act_q);
        CMD_RD:  cmd_ready = xsrd_idle && wtr_idle;
        CMD_WR:  cmd_ready = xsnr_idle;
        CMD_PRE: cmd_ready = xsnr_idle && wr_idle[cmd_bank];
        CMD_REF: cmd_ready = xsnr_idle && rfc_idle;
        CMD_SRE: cmd_ready = xsnr_idle && rfc_idle;
        CMD_SRX: cmd_ready = 1'b0;
        default: cmd_ready = 1'b0;
      endcase
    end
  end

  refresh_tracker #(.MAX_POSTED(MAX_POSTED), .CNT_W(CNT_W)) u_refdebt (
    .clk(clk), .rst_n(rst_n), .due(refresh_due),
    .ref_fire(fire && ct == CMD_REF),
    .cnt(posted_cnt), .ovf(posted_ovf)
  );
endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int unsigned CLK_PS     = 4000,
  parameter int unsigned T_RFC_PS   = 75000,
  parameter int unsigned T_WTR_CK   = 1,
  parameter int unsigned WR_DATA_CK = 3,
  parameter int unsigned MAX_POSTED = 8,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned CNT_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_type,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              cmd_ready,
  input logic              refresh_due,
  input logic [CNT_W-1:0]  posted_cnt,
  input logic              posted_ovf
);
  localparam logic [15:0] RFC_GAP = 16'((T_RFC_PS + CLK_PS - 1) / CLK_PS);
  localparam logic [15:0] WTR_GAP = 16'(WR_DATA_CK + T_WTR_CK);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_POSTED);

  logic fire;
  assign fire = cmd_valid && cmd_ready;

  // independent age counters, in cycles since the last issue of each kind
  logic [15:0] since_ref, since_wr;
  logic chk_in_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref <= 16'hFFFF;
      since_wr  <= 16'hFFFF;
      chk_in_sr <= 1'b0;
    end else begin
      if (fire && cmd_type == 3'd5) since_ref <= 16'd1;
      else if (since_ref != 16'hFFFF) since_ref <= since_ref + 16'd1;
      if (fire && cmd_type == 3'd3) since_wr <= 16'd1;
      else if (since_wr != 16'hFFFF) since_wr <= since_wr + 16'd1;
      if (fire && cmd_type == 3'd6) chk_in_sr <= 1'b1;
      if (fire && cmd_type == 3'd7) chk_in_sr <= 1'b0;
    end
  end

  a_r1_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (cmd_type == 3'd1 || cmd_type == 3'd5) |-> since_ref >= RFC_GAP);

  a_r5_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_type == 3'd2 |-> since_wr >= WTR_GAP);

  a_r7_sr_only_exit: assert property (@(posedge clk) disable iff (!rst_n)
    fire && chk_in_sr |-> (cmd_type == 3'd7 || cmd_type == 3'd0));

  a_r7_no_exit_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_in_sr && cmd_type == 3'd7 |-> !cmd_ready);

  a_r8_nop_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_type == 3'd0 |-> cmd_ready);

  a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
    posted_cnt <= CAP);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_due && !(fire && cmd_type == 3'd5) |=> $stable(posted_cnt));

  a_r10_ovf_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    posted_ovf |-> (refresh_due && posted_cnt == CAP));
endmodule

bind cmd_timing_guard guard_checker #(
  .CLK_PS(CLK_PS), .T_RFC_PS(T_RFC_PS), .T_WTR_CK(T_WTR_CK),
  .WR_DATA_CK(WR_DATA_CK), .MAX_POSTED(MAX_POSTED),
  .BANK_W(BANK_W), .CNT_W(CNT_W)
) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
  .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .refresh_due(refresh_due),
  .posted_cnt(posted_cnt), .posted_ovf(posted_ovf)
);

// File: tb/cmd_timing_guard_tb_top.sv
`timescale 1ns/1ps
module cmd_timing_guard_tb_top;
  localparam int NB   = 4;
  localparam int CLKP = 4000;
  localparam int RFC  = (75000 + CLKP - 1) / CLKP;   // 19
  localparam int RP   = (20000 + CLKP - 1) / CLKP;   // 5
  localparam int RRD  = (15000 + CLKP - 1) / CLKP;   // 4
  localparam int WRC  = (15000 + CLKP - 1) / CLKP;   // 4
  localparam int XSNR = (75000 + CLKP - 1) / CLKP;   // 19
  localparam int XSRD = 200;
  localparam int WDAT = 3;
  localparam int WTR  = 1;
  localparam int CAPV = 8;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, SRE = 3'd6, SRX = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_type = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic cmd_ready;
  logic refresh_due = 1'b0;
  logic [3:0] posted_cnt;
  logic posted_ovf;

  always #2 clk = ~clk;

  cmd_timing_guard #(
    .NUM_BANKS(NB), .CLK_PS(CLKP), .T_RFC_PS(75000), .T_RP_PS(20000),
    .T_RRD_PS(15000), .T_WR_PS(15000), .T_XSNR_PS(75000), .T_WTR_CK(WTR),
    .T_XSRD_CK(XSRD), .WR_DATA_CK(WDAT), .MAX_POSTED(CAPV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .refresh_due(refresh_due),
    .posted_cnt(posted_cnt), .posted_ovf(posted_ovf)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model: last-issue cycle numbers
  int m_cyc = 0;
  int last_ref = -1000, last_act = -1000, last_wr_any = -1000, last_srx = -1000;
  int last_pre [NB];
  int last_wr  [NB];
  int last_act_bank = 0;
  bit m_in_sr = 0;
  int m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, m_cyc);
    end
  endtask

  function automatic bit exp_ready(input logic [2:0] t, input int b);
    int age_x;
    age_x = m_cyc - last_srx;
    if (m_in_sr) return (t == SRX) || (t == NOP);
    case (t)
      NOP: return 1;
      ACT: return (m_cyc - last_ref >= RFC) && (m_cyc - last_pre[b] >= RP) &&
                  (b == last_act_bank || m_cyc - last_act >= RRD) && age_x >= XSNR;
      RD:  return (m_cyc - last_wr_any >= WDAT + WTR) && age_x >= XSRD;
      WR:  return age_x >= XSNR;
      PRE: return (m_cyc - last_wr[b] >= WDAT + WRC) && age_x >= XSNR;
      REF: return (m_cyc - last_ref >= RFC) && age_x >= XSNR;
      SRE: return (m_cyc - last_ref >= RFC) && age_x >= XSNR;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] t);
    if (m_in_sr) return "R7";
    case (t)
      NOP: return "R8";
      ACT: return "R1,R2,R3,R6";
      RD:  return "R5,R6";
      WR:  return "R6";
      PRE: return "R4,R6";
      REF: return "R1,R6";
      SRE: return "R1,R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] t, input int b,
                      input logic due, output bit fired);
    bit er, eo, rf;
    cmd_valid = v; cmd_type = t; cmd_bank = 2'(b); refresh_due = due;
    @(negedge clk);
    er = exp_ready(t, b);
    chk(cmd_ready === er, tag_for(t), int'(cmd_ready), int'(er));
    rf = v && er && (t == REF);
    eo = due && !rf && (m_cnt == CAPV);
    chk(posted_ovf === eo, "R10", int'(posted_ovf), int'(eo));
    chk(posted_cnt == 4'(m_cnt), "R9", int'(posted_cnt), m_cnt);
    fired = v && er;
    @(posedge clk);
    if (fired) begin
      case (t)
        ACT: begin last_act = m_cyc; last_act_bank = b; end
        WR:  begin last_wr[b] = m_cyc; last_wr_any = m_cyc; end
        PRE: last_pre[b] = m_cyc;
        REF: last_ref = m_cyc;
        SRE: m_in_sr = 1;
        SRX: begin m_in_sr = 0; last_srx = m_cyc; end
        default: ;
      endcase
    end
    if (due && !rf) begin
      if (m_cnt != CAPV) m_cnt++;
    end else if (rf && !due && m_cnt != 0) m_cnt--;
    m_cyc++;
    #1;
  endtask

  task automatic idle(input int n);
    bit f;
    for (int i = 0; i < n; i++) step(0, NOP, 0, 0, f);
  endtask

  // hold one command until accepted (refused command stays on the inputs)
  task automatic offer(input logic [2:0] t, input int b, input bit rnd_due);
    bit f;
    f = 0;
    for (int i = 0; i < 400 && !f; i++)
      step(1, t, b, rnd_due ? (($urandom % 13) == 0) : 1'b0, f);
    if (!f) chk(0, "R8 held command never accepted", 0, 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit f;
    logic [2:0] seq [5];
    seq[0] = ACT; seq[1] = RD; seq[2] = WR; seq[3] = PRE; seq[4] = REF;
    for (int b = 0; b < NB; b++) begin last_pre[b] = -1000; last_wr[b] = -1000; end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset state; every command but exit ready right away
    @(negedge clk);
    chk(posted_cnt == 0, "R11", int'(posted_cnt), 0);
    chk(posted_ovf == 0, "R11", int'(posted_ovf), 0);
    @(posedge clk); #1;
    for (int t = 0; t < 8; t++) begin
      cmd_valid = 0; cmd_type = 3'(t); cmd_bank = 0; refresh_due = 0;
      @(negedge clk);
      chk(cmd_ready === (t != 7), "R11", int'(cmd_ready), int'(t != 7));
      @(posedge clk); #1;
      m_cyc++;
    end

    // pair sweep: each first command, each second command, same and other bank
    for (int a = 0; a < 5; a++)
      for (int c = 0; c < 5; c++)
        for (int sb = 0; sb < 2; sb++) begin
          offer(seq[a], 0, 0);
          offer(seq[c], sb ? 1 : 0, 0);
          idle(25);
        end

    // R3: activate to same bank is not held by the cross-bank spacing
    offer(ACT, 2, 0);
    offer(ACT, 2, 0);
    offer(ACT, 3, 0);
    idle(25);

    // R7/R6: self-refresh sequence
    offer(SRE, 0, 0);
    for (int i = 0; i < 6; i++) step(1, seq[i % 5], i % NB, 0, f); // all refused
    step(1, NOP, 0, 0, f);
    offer(SRX, 0, 0);
    step(1, SRX, 0, 0, f);   // exit refused outside self-refresh
    offer(WR, 1, 0);         // waits XSNR
    offer(RD, 1, 0);         // waits XSRD
    idle(10);

    // R9/R10: refresh debt up to and past the cap, then repay
    for (int i = 0; i < 11; i++) step(0, NOP, 0, 1, f);
    offer(REF, 0, 0);
    step(1, NOP, 0, 1, f);
    for (int i = 0; i < 11; i++) begin offer(REF, 0, 0); end
    idle(5);
    // due and refresh in the same cycle leave the count unchanged
    for (int i = 0; i < 3; i++) step(0, NOP, 0, 1, f);
    idle(RFC);
    step(1, REF, 0, 1, f);
    idle(3);

    // randomized held-command stream
    for (int n = 0; n < 1500; n++) begin
      int r, b;
      logic [2:0] t;
      r = $urandom % 64;
      b = $urandom % NB;
      if (m_in_sr) t = SRX;
      else if (r == 0) t = SRE;
      else if (r < 6) t = NOP;
      else t = seq[r % 5];
      if (($urandom % 4) == 0) step(0, 3'($urandom % 8), b, ($urandom % 13) == 0, f);
      offer(t, b, 1);
    end
    idle(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule